// File: doc/BRIEF.md
# Three-Wire Framed Serial Write Receiver

This block is the write side of a three-wire serial control link. An external controller pulls an active-low frame select, then clocks 16-bit words onto a data line, most significant bit first. The block shifts bits in on the falling edge of the serial clock and counts them. When a word completes, it hands the word to the master-clock domain through a toggle-flag synchronizer. Several words may follow one another inside a single frame. Raising the frame select early throws away an incomplete word.

In the master-clock domain, each word appears for one cycle on `word_out`, with `word_valid` high. A small decoder then turns the word into a register write. The top two bits choose the target: `00` is the control register, `01` is tuning word A, `10` is tuning word B and `11` is the phase offset.

A tuning word is 28 bits wide and takes two writes to the same target, lower 14 bits first, then upper 14 bits. The decoder tracks this sequence in three states:
- `ST_IDLE`: no lower half is pending.
- `ST_HALF_A`: a lower half for tuning word A is held.
- `ST_HALF_B`: a lower half for tuning word B is held.

Transitions:
- `IDLE->HALF_A` and `IDLE->HALF_B`: a first half is written.
- `HALF_A->IDLE` and `HALF_B->IDLE`: the matching upper half commits the register, or a control or phase write cancels the pending half.
- `HALF_A->HALF_B` and `HALF_B->HALF_A`: a write to the other tuning target replaces the pending half with a new lower half.

Top module: `serial_word_port`

## Requirements
- R1: After reset, `word_valid` is 0 and the control, tuning A, tuning B and phase registers are all 0.
- R2: Each complete word appears on `word_out` exactly as sent. Bits are sent bit 15 first, down to bit 0, and each bit is sampled on a falling edge of `sclk` while `frame_n` is low.
- R3: Words sent back to back within one low period of `frame_n` are each delivered, in order.
- R4: Raising `frame_n` before 16 bits have arrived discards the partial word. No strobe follows, and the next frame starts again at bit 15.
- R5: `word_valid` is high for exactly one master-clock cycle per delivered word.
- R6: A word whose bits 15:14 are `00` loads bits 13:0 into `ctrl_reg`.
- R7: For tuning target A (bits 15:14 = `01`) or B (`10`), the first write holds bits 13:0 as the lower half and leaves the register unchanged. A second consecutive write to the same target loads {second bits 13:0, held lower half} into the 28-bit register in one update.
- R8: A pending lower half is dropped by any intervening write that is not to the same target. A write to the other tuning target becomes that target's new lower half.
- R9: A word whose bits 15:14 are `11` loads bits 11:0 into `phase_reg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock, data sampled on falling edge |
| sdata | input | 1 | Serial data, MSB first |
| word_valid | output | 1 | One-cycle strobe for a received word |
| word_out | output | 16 | Received word |
| ctrl_reg | output | 14 | Control register |
| tune_a | output | 28 | Tuning word A |
| tune_b | output | 28 | Tuning word B |
| phase_reg | output | 12 | Phase offset register |

## Verification
A bit counter that is out of step shows up as a rotated word at the scoreboard, on the next strobe after the fault. A counter that is not cleared by a frame abort corrupts the first word of the following frame. A decoder left in the wrong half-pending state either commits a tuning register too early or fails to commit one. Both are visible at the register ports within a few master cycles of the second write.

// File: rtl/swp_pkg.sv
package swp_pkg;
    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL  = 2'b00,
        SEL_TUNEA = 2'b01,
        SEL_TUNEB = 2'b10,
        SEL_PHASE = 2'b11
    } sel_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_HALF_A = 2'b01,
        ST_HALF_B = 2'b10
    } half_st_e;
endpackage

// File: rtl/swp_shifter.sv
module swp_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              sclk,
    input  logic              frame_n,
    input  logic              sdata,
    input  logic              rst_n,
    output logic [WORD_W-1:0] word_hold,
    output logic              flag_tgl
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    logic [CNT_W-1:0]  bit_cnt;
    logic [WORD_W-2:0] shreg;

    // Frame high clears the partial word and counter (R4)
    always_ff @(negedge sclk or posedge frame_n) begin
        if (frame_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else begin
            shreg   <= {shreg[WORD_W-3:0], sdata};
            bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
        end
    end

    // Completed word captured and flagged by a toggle (R2, R3)
    always_ff @(negedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            word_hold <= '0;
            flag_tgl  <= 1'b0;
        end else if (!frame_n && bit_cnt == LAST_BIT) begin
            word_hold <= {shreg, sdata};
            flag_tgl  <= ~flag_tgl;
        end
    end
endmodule

// File: rtl/swp_sync.sv
module swp_sync #(
    parameter int WORD_W = 16,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tgl_in,
    input  logic [WORD_W-1:0] word_in,
    output logic              valid,
    output logic [WORD_W-1:0] word_out
);
    logic [STAGES:0] chain;
    logic            edge_seen;

    assign edge_seen = chain[STAGES] ^ chain[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain    <= '0;
            valid    <= 1'b0;
            word_out <= '0;
        end else begin
            chain <= {chain[STAGES-1:0], tgl_in};
            valid <= edge_seen;
            if (edge_seen) word_out <= word_in;
        end
    end

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid); // R5
    AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(word_out) |-> $past(edge_seen)); // R2
endmodule

// File: rtl/swp_decoder.sv
module swp_decoder
    import swp_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int PHASE_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    valid,
    input  logic [WORD_W-1:0]       word_in,
    output logic [WORD_W-SEL_W-1:0] ctrl_reg,
    output logic [2*(WORD_W-SEL_W)-1:0] tune_a,
    output logic [2*(WORD_W-SEL_W)-1:0] tune_b,
    output logic [PHASE_W-1:0]      phase_reg
);
    localparam int DATA_W = WORD_W - SEL_W;

    sel_e              sel;
    logic [DATA_W-1:0] data;
    half_st_e          state_q, state_d;
    logic [DATA_W-1:0] low_q;

    assign sel  = sel_e'(word_in[WORD_W-1 -: SEL_W]);
    assign data = word_in[DATA_W-1:0];

    always_comb begin
        state_d = state_q;
        if (valid) begin
            unique case (sel)
                SEL_TUNEA: state_d = (state_q == ST_HALF_A) ? ST_IDLE : ST_HALF_A;
                SEL_TUNEB: state_d = (state_q == ST_HALF_B) ? ST_IDLE : ST_HALF_B;
                SEL_CTRL,
                SEL_PHASE: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_q     <= '0;
            ctrl_reg  <= '0;
            tune_a    <= '0;
            tune_b    <= '0;
            phase_reg <= '0;
        end else if (valid) begin
            unique case (sel)
                SEL_CTRL:  ctrl_reg <= data;
                SEL_PHASE: phase_reg <= data[PHASE_W-1:0];
                SEL_TUNEA: begin
                    if (state_q == ST_HALF_A) tune_a <= {data, low_q};
                    else                      low_q  <= data;
                end
                SEL_TUNEB: begin
                    if (state_q == ST_HALF_B) tune_b <= {data, low_q};
                    else                      low_q  <= data;
                end
            endcase
        end
    end

    AST_CTRL_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_reg) |-> $past(valid && sel == SEL_CTRL)); // R6
    AST_TUNEA_ATOMIC: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tune_a) |-> $past(valid && sel == SEL_TUNEA && state_q == ST_HALF_A)); // R7
    AST_TUNEB_ATOMIC: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tune_b) |-> $past(valid && sel == SEL_TUNEB && state_q == ST_HALF_B)); // R7
    AST_PHASE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(phase_reg) |-> $past(valid && sel == SEL_PHASE)); // R9
    AST_CANCEL_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && (sel == SEL_CTRL || sel == SEL_PHASE)) |=> state_q == ST_IDLE); // R8
endmodule

// File: rtl/serial_word_port.sv
module serial_word_port
    import swp_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int PHASE_W     = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frame_n,
    input  logic                    sclk,
    input  logic                    sdata,
    output logic                    word_valid,
    output logic [WORD_W-1:0]       word_out,
    output logic [WORD_W-SEL_W-1:0] ctrl_reg,
    output logic [2*(WORD_W-SEL_W)-1:0] tune_a,
    output logic [2*(WORD_W-SEL_W)-1:0] tune_b,
    output logic [PHASE_W-1:0]      phase_reg
);
    logic [WORD_W-1:0] hold_w;
    logic              tgl_w;

    swp_shifter #(.WORD_W(WORD_W)) u_shift (
        .sclk(sclk), .frame_n(frame_n), .sdata(sdata), .rst_n(rst_n),
        .word_hold(hold_w), .flag_tgl(tgl_w)
    );

    swp_sync #(.WORD_W(WORD_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .tgl_in(tgl_w), .word_in(hold_w),
        .valid(word_valid), .word_out(word_out)
    );

    swp_decoder #(.WORD_W(WORD_W), .PHASE_W(PHASE_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .valid(word_valid), .word_in(word_out),
        .ctrl_reg(ctrl_reg), .tune_a(tune_a), .tune_b(tune_b), .phase_reg(phase_reg)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !word_valid); // R1
endmodule

// File: tb/sim_serial_word_port.sv
module sim_serial_word_port;
    logic clk = 1'b0, rst_n = 1'b0, frame_n = 1'b1, sclk = 1'b1, sdata = 1'b0;
    logic        word_valid;
    logic [15:0] word_out;
    logic [13:0] ctrl_reg;
    logic [27:0] tune_a, tune_b;
    logic [11:0] phase_reg;

    int n_chk = 0, n_fail = 0;
    logic [15:0] exp_q[$];
    logic [13:0] m_ctrl = '0, m_low = '0;
    logic [27:0] m_a = '0, m_b = '0;
    logic [11:0] m_ph = '0;
    int m_pend = 0;
    bit done = 0;

    always #5 clk = ~clk;

    serial_word_port u0 (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .sclk(sclk), .sdata(sdata),
        .word_valid(word_valid), .word_out(word_out), .ctrl_reg(ctrl_reg),
        .tune_a(tune_a), .tune_b(tune_b), .phase_reg(phase_reg)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected register model derived from R6-R9
    task automatic model(input logic [15:0] w);
        case (w[15:14])
            2'b00: begin m_ctrl = w[13:0]; m_pend = 0; end
            2'b11: begin m_ph = w[11:0]; m_pend = 0; end
            2'b01: if (m_pend == 1) begin m_a = {w[13:0], m_low}; m_pend = 0; end
                   else begin m_low = w[13:0]; m_pend = 1; end
            default: if (m_pend == 2) begin m_b = {w[13:0], m_low}; m_pend = 0; end
                   else begin m_low = w[13:0]; m_pend = 2; end
        endcase
    endtask

    task automatic send_bits(input logic [15:0] w, input int nb);
        for (int i = 15; i > 15 - nb; i--) begin
            sdata = w[i];
            #10 sclk = 1'b0;
            #20 sclk = 1'b1;
            #10;
        end
    endtask

    task automatic send_word(input logic [15:0] w);
        exp_q.push_back(w);
        model(w);
        send_bits(w, 16);
    endtask

    task automatic open_frame();
        frame_n = 1'b0; #20;
    endtask

    task automatic close_frame();
        #10 frame_n = 1'b1; #40;
    endtask

    task automatic one_word(input logic [15:0] w);
        open_frame(); send_word(w); close_frame();
    endtask

    task automatic check_regs(input string tag);
        repeat (20) @(negedge clk);
        chk(ctrl_reg == m_ctrl, {tag, " ctrl"}, 32'(ctrl_reg), 32'(m_ctrl));
        chk(tune_a == m_a, {tag, " tune_a"}, 32'(tune_a), 32'(m_a));
        chk(tune_b == m_b, {tag, " tune_b"}, 32'(tune_b), 32'(m_b));
        chk(phase_reg == m_ph, {tag, " phase"}, 32'(phase_reg), 32'(m_ph));
    endtask

    // Scoreboard monitor: R2, R3, R4, R5
    logic prev_valid = 1'b0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (word_valid && prev_valid)
                chk(1'b0, "R5 strobe longer than one cycle", 32'd1, 32'd0);
            if (word_valid && !prev_valid) begin
                if (exp_q.size() == 0) chk(1'b0, "R4 unexpected word", 32'(word_out), 32'd0);
                else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    chk(word_out == e, "R2 R3 word content", 32'(word_out), 32'(e));
                end
            end
        end
        prev_valid = word_valid;
    end

    initial begin
        #2_000_000;
        chk(1'b0, "watchdog", 32'd0, 32'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(word_valid == 1'b0, "R1 valid", 32'(word_valid), 32'd0);
        chk({ctrl_reg, phase_reg} == '0 && tune_a == '0 && tune_b == '0, "R1 regs", 32'(ctrl_reg), 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        one_word(16'h1234);              check_regs("R6 control");
        one_word(16'hCABC);              check_regs("R9 phase");
        one_word(16'h5555);              check_regs("R7 first half held");
        one_word(16'h6AAA);              check_regs("R7 commit A");
        // back-to-back in one frame
        open_frame();
        send_word(16'h8F0F); send_word(16'hB0F0); send_word(16'h3FFF);
        close_frame();                   check_regs("R3 back to back");
        // partial frame abort then a full word
        open_frame(); send_bits(16'hFFFF, 7); close_frame();
        one_word(16'hC123);              check_regs("R4 abort then phase");
        // pending A replaced by B
        open_frame();
        send_word(16'h4001); send_word(16'h8222); send_word(16'h8333);
        close_frame();                   check_regs("R8 switch target");
        // pending A cancelled by control
        one_word(16'h4444); one_word(16'h0007); one_word(16'h7FFF);
        check_regs("R8 cancel by control");
        one_word(16'h4000);              check_regs("R7 final commit A");
        one_word(16'hFFFF);              check_regs("R9 all ones");

        chk(exp_q.size() == 0, "R3 all words delivered", 32'(exp_q.size()), 32'd0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule